// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block turns one fast source clock into three banks of divided clocks plus a feedback clock. Each bank has its own select bit that chooses between a small even ratio and twice that ratio. The feedback clock chooses between two larger even ratios, one of which is not a power of two. Every output runs at exactly 50% duty cycle. All outputs come from a single shared phase counter, so every rising edge of a slower output lands on a rising edge of each faster one.

The divider clock is normally the fast source. For static test, a bypass control replaces it with a reference clock. That reference is taken from either a single-ended input or a differential pair, chosen by a pick bit. Each bank drives seven identical copies of its clock, together with a driver enable that models a tri-state pad. An output-enable input gates the bank drivers but never the feedback clock. The driver enables and the ratio selects change only at safe points, so no output ever shows a shortened pulse.

Top module: `bank_clock_divider`

## Requirements
- R1: A bank whose select bit is 0 divides the divider clock by 2. A select bit of 1 divides it by 4. High and low times are each exactly half the ratio.
- R2: The feedback output divides the divider clock by 8 when its select bit is 0 and by 12 when it is 1, with exactly 50% duty cycle.
- R3: All seven bits of a bank's output vector always carry the same value.
- R4: While reset is high, all bank outputs, the feedback output and all driver enables are low. At the first divider-clock edge after reset is released, every bank output and the feedback output rise together.
- R5: Every rising edge of the feedback output coincides with a rising edge of all three bank outputs.
- R6: A change to any select bit takes effect only at the next edge where all currently running outputs rise together. As a result, every completed high or low run lasts either 1 or 2 divider-clock cycles on a bank and either 4 or 6 cycles on the feedback output, and the new ratio is in force within 24 cycles.
- R7: While output-enable is low, all three driver enables are low (the bank pads are high impedance). The feedback output keeps toggling at its selected ratio regardless of output-enable.
- R8: A bank's driver enable changes only on an edge where that bank's output was low just before the edge.
- R9: A reference pick bit of 0 selects the single-ended reference. A pick bit of 1 selects the differential pair, which is read as high when the positive leg is high and the negative leg is low.
- R10: With bypass high, the selected reference clocks the dividers in place of the source clock. With bypass low, the source clock is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock (stands in for the oscillator) |
| rst | input | 1 | Synchronous reset, active high, in the divider clock domain |
| ref_se | input | 1 | Single-ended reference clock |
| ref_dp | input | 1 | Differential reference, positive leg |
| ref_dn | input | 1 | Differential reference, negative leg |
| ref_pick | input | 1 | Reference pick: 0 single-ended, 1 differential |
| bypass | input | 1 | 1 = dividers clocked by the selected reference |
| oe | input | 1 | Bank output enable, active high |
| sel_a | input | 1 | Bank A ratio: 0 = /2, 1 = /4 |
| sel_b | input | 1 | Bank B ratio: 0 = /2, 1 = /4 |
| sel_c | input | 1 | Bank C ratio: 0 = /2, 1 = /4 |
| sel_fb | input | 1 | Feedback ratio: 0 = /8, 1 = /12 |
| bank_a | output | COPIES (7) | Bank A clock copies |
| bank_b | output | COPIES (7) | Bank B clock copies |
| bank_c | output | COPIES (7) | Bank C clock copies |
| en_a | output | 1 | Bank A driver enable (0 = high impedance) |
| en_b | output | 1 | Bank B driver enable |
| en_c | output | 1 | Bank C driver enable |
| fb_out | output | 1 | Feedback clock, never disabled |

## Verification
The bench steps through all sixteen select combinations and then a seeded random sequence. Ratio changes land at arbitrary phases, where a design that switches at once would emit a one-cycle runt or a stretched run on the feedback /12 to /8 boundary. A continuous monitor flags any completed run outside the legal lengths. It also flags any driver enable that moves while its bank is high; a naive gate would clip a pulse there. Edge alignment is checked at every feedback rise, which catches dividers that were built as separate counters and drift out of phase. Finally, bypass with each reference choice is timed in absolute nanoseconds, so a swapped reference pick or a bypass that still uses the source clock shows up as a wrong feedback period.

// File: rtl/bank_clock_divider.sv
`timescale 1ns/1ps
module bank_clock_divider #(
  parameter int COPIES = 7,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4,
  parameter int FB_LO  = 8,
  parameter int FB_HI  = 12
) (
  input  logic              clk_src,
  input  logic              rst,
  input  logic              ref_se,
  input  logic              ref_dp,
  input  logic              ref_dn,
  input  logic              ref_pick,
  input  logic              bypass,
  input  logic              oe,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c,
  input  logic              sel_fb,
  output logic [COPIES-1:0] bank_a,
  output logic [COPIES-1:0] bank_b,
  output logic [COPIES-1:0] bank_c,
  output logic              en_a,
  output logic              en_b,
  output logic              en_c,
  output logic              fb_out
);

  function automatic int gcd(input int x, input int y);
    int a = x, b = y, t;
    while (b != 0) begin
      t = a % b; a = b; b = t;
    end
    return a;
  endfunction

  function automatic int lcm(input int x, input int y);
    return (x / gcd(x, y)) * y;
  endfunction

  localparam int PHASES = lcm(lcm(DIV_LO, DIV_HI), lcm(FB_LO, FB_HI));
  localparam int PW     = $clog2(PHASES);

  function automatic logic first_half(input int phase, input int n);
    return (phase % n) < (n / 2);
  endfunction

  logic          ref_clk, div_clk;
  logic [PW-1:0] ph;
  logic [2:0]    sel_in, bsel, q, en;
  logic          fsel, qf, at_common;

  assign ref_clk = ref_pick ? (ref_dp & ~ref_dn) : ref_se;
  assign div_clk = bypass ? ref_clk : clk_src;
  assign sel_in  = {sel_c, sel_b, sel_a};

  assign at_common = fsel ? ((int'(ph) % FB_HI) == FB_HI - 1)
                          : ((int'(ph) % FB_LO) == FB_LO - 1);

  always_ff @(posedge div_clk) begin
    if (rst) begin
      ph   <= '0;
      qf   <= 1'b0;
      fsel <= sel_fb;
      bsel <= sel_in;
    end else begin
      if (at_common || ph == PW'(PHASES - 1)) ph <= '0;
      else                                    ph <= ph + 1'b1;
      if (at_common) begin
        fsel <= sel_fb;
        bsel <= sel_in;
      end
      qf <= first_half(int'(ph), fsel ? FB_HI : FB_LO);
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_bank
    always_ff @(posedge div_clk) begin
      if (rst) begin
        q[i]  <= 1'b0;
        en[i] <= 1'b0;
      end else begin
        q[i] <= first_half(int'(ph), bsel[i] ? DIV_HI : DIV_LO);
        if (!q[i]) en[i] <= oe;
      end
    end

    a_r1_lo_ratio_toggles: assert property (@(posedge div_clk) disable iff (rst)
      (!$past(rst) && !$past(bsel[i]) && !bsel[i]) |-> q[i] != $past(q[i]));

    a_r8_enable_moves_low: assert property (@(posedge div_clk) disable iff (rst)
      (en[i] != $past(en[i])) |-> !$past(q[i]));
  end

  a_r5_fb_rise_aligned: assert property (@(posedge div_clk) disable iff (rst)
    $rose(qf) |-> ($rose(q[0]) && $rose(q[1]) && $rose(q[2])));

  a_r6_switch_while_low: assert property (@(posedge div_clk) disable iff (rst)
    (fsel != $past(fsel) || bsel != $past(bsel)) |-> (!qf && q == 3'b000 && ph == '0));

  a_r6_new_ratio_rises: assert property (@(posedge div_clk) disable iff (rst)
    (fsel != $past(fsel) || bsel != $past(bsel)) |=> (qf && q == 3'b111));

  assign bank_a = {COPIES{q[0]}};
  assign bank_b = {COPIES{q[1]}};
  assign bank_c = {COPIES{q[2]}};
  assign en_a   = en[0];
  assign en_b   = en[1];
  assign en_c   = en[2];
  assign fb_out = qf;

endmodule

// File: tb/test_bank_clock_divider.sv
`timescale 1ns/1ps
module test_bank_clock_divider;
  logic clk_src = 0, rst = 1, ref_se = 0, ref_dp = 0, ref_dn;
  logic ref_pick = 0, bypass = 0, oe = 1;
  logic sel_a = 0, sel_b = 0, sel_c = 0, sel_fb = 0;
  logic [6:0] bank_a, bank_b, bank_c;
  logic en_a, en_b, en_c, fb_out;

  int vectors = 0, miscompares = 0;
  bit mon_on = 0, done = 0;
  logic [3:0] trace [0:47];

  assign ref_dn = ~ref_dp;
  always #4  clk_src = ~clk_src;
  always #20 ref_se  = ~ref_se;
  always #28 ref_dp  = ~ref_dp;

  bank_clock_divider i_bank_clock_divider (
    .clk_src(clk_src), .rst(rst), .ref_se(ref_se), .ref_dp(ref_dp), .ref_dn(ref_dn),
    .ref_pick(ref_pick), .bypass(bypass), .oe(oe),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
    .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c),
    .en_a(en_a), .en_b(en_b), .en_c(en_c), .fb_out(fb_out));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input bit s, input bit fb);
    if (fb) return s ? 6 : 4;
    return s ? 2 : 1;
  endfunction

  function automatic bit copies_same(input logic [6:0] v);
    return v == 7'h00 || v == 7'h7f;
  endfunction

  task automatic capture();
    for (int i = 0; i < 48; i++) begin
      @(negedge clk_src);
      trace[i] = {fb_out, bank_c[0], bank_b[0], bank_a[0]};
      check(copies_same(bank_a) && copies_same(bank_b) && copies_same(bank_c), "R3",
            {bank_a, bank_b, bank_c}, 0);
    end
  endtask

  task automatic check_runs(input int j, input int exp, input string req);
    int run = 1;
    bit first = 1;
    for (int i = 1; i < 48; i++) begin
      if (trace[i][j] == trace[i-1][j]) run++;
      else begin
        if (!first) check(run == exp, req, run, exp);
        first = 0;
        run = 1;
      end
    end
  endtask

  task automatic apply(input bit a, input bit b, input bit c, input bit f);
    @(negedge clk_src);
    sel_a = a; sel_b = b; sel_c = c; sel_fb = f;
    repeat (40) @(negedge clk_src);
    capture();
    check_runs(0, half_of(a, 0), "R1");
    check_runs(1, half_of(b, 0), "R1");
    check_runs(2, half_of(c, 0), "R1");
    check_runs(3, half_of(f, 1), "R2");
    for (int i = 1; i < 48; i++)
      if (trace[i][3] && !trace[i-1][3])
        check(trace[i][2:0] == 3'b111 && trace[i-1][2:0] == 3'b000, "R5",
              {trace[i-1][2:0], trace[i][2:0]}, 6'b000111);
  endtask

  task automatic fb_period(input longint exp, input string req);
    longint t0, t1;
    @(posedge fb_out); t0 = $time;
    @(posedge fb_out); t1 = $time;
    check(t1 - t0 == exp, req, t1 - t0, exp);
  endtask

  // R6 and R8 run-length and enable monitor
  int mrun [4];
  bit mfirst [4];
  logic [3:0] mprev;
  logic [2:0] eprev;
  always @(negedge clk_src) begin
    logic [3:0] cur;
    logic [2:0] ecur;
    cur  = {fb_out, bank_c[0], bank_b[0], bank_a[0]};
    ecur = {en_c, en_b, en_a};
    if (!mon_on) begin
      for (int j = 0; j < 4; j++) begin mfirst[j] = 1; mrun[j] = 1; end
    end else begin
      for (int j = 0; j < 4; j++) begin
        if (cur[j] == mprev[j]) mrun[j]++;
        else begin
          if (!mfirst[j]) begin
            if (j == 3) check(mrun[j] == 4 || mrun[j] == 6, "R6", mrun[j], 4);
            else        check(mrun[j] == 1 || mrun[j] == 2, "R6", mrun[j], 1);
          end
          mfirst[j] = 0;
          mrun[j] = 1;
        end
      end
      for (int j = 0; j < 3; j++)
        if (ecur[j] != eprev[j]) check(mprev[j] == 1'b0, "R8", mprev[j], 0);
    end
    mprev = cur;
    eprev = ecur;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_src);
    check(bank_a == 0 && bank_b == 0 && bank_c == 0 && fb_out == 0, "R4",
          {bank_a, bank_b, bank_c, fb_out}, 0);
    check({en_a, en_b, en_c} == 3'b000, "R4", {en_a, en_b, en_c}, 0);
    rst = 0;
    @(posedge clk_src); #1;
    check(bank_a == 7'h7f && bank_b == 7'h7f && bank_c == 7'h7f && fb_out == 1, "R4",
          {bank_a[0], bank_b[0], bank_c[0], fb_out}, 4'hf);
    mon_on = 1;

    for (int k = 0; k < 16; k++) apply(k[0], k[1], k[2], k[3]);
    repeat (12) begin
      logic [3:0] r;
      r = 4'($urandom);
      apply(r[0], r[1], r[2], r[3]);
    end

    // R7: output-enable low
    @(negedge clk_src); oe = 0;
    repeat (10) @(negedge clk_src);
    check({en_a, en_b, en_c} == 3'b000, "R7", {en_a, en_b, en_c}, 0);
    capture();
    check_runs(3, half_of(sel_fb, 1), "R7");
    @(negedge clk_src); oe = 1;
    repeat (10) @(negedge clk_src);
    check({en_a, en_b, en_c} == 3'b111, "R7", {en_a, en_b, en_c}, 7);

    // R9 / R10: bypass and reference pick
    mon_on = 0;
    @(negedge clk_src); sel_fb = 0;
    repeat (40) @(negedge clk_src);
    bypass = 1; ref_pick = 0;
    #2000;
    fb_period(8 * 40, "R10");
    ref_pick = 1;
    #3000;
    fb_period(8 * 56, "R9");
    sel_fb = 1;
    #3000;
    fb_period(12 * 56, "R9");
    ref_pick = 0;
    #3000;
    fb_period(12 * 40, "R10");
    bypass = 0;
    #1000;
    fb_period(12 * 8, "R10");

    done = 1;
    summary();
    $finish;
  end
endmodule